// File: doc/BRIEF.md
# Rank and Bank Request Dispatcher with Round-Robin Response Merge

This block stands between a central memory request queue and one scheduler per DRAM bank. Requests are written into an internal queue of parameterised depth. Each request address carries a bank index just above the column bits and a rank index just above the bank bits. Together these two fields select one of the bank schedulers. In each cycle the dispatcher looks at the oldest few queue entries and sends as many as it can, in queue order. It stops at the first entry whose bank is not ready, or whose bank already took an entry earlier in the same cycle.

On the return path every bank scheduler can offer a completion. A round-robin arbiter accepts at most one of them per cycle and writes it, tagged with its bank slot, into a shared response queue. When that queue is full, no bank is offered ready. The arbiter's priority pointer moves only when a transfer is granted.

Top module: `rank_bank_dispatch`

## Requirements
- R1: The bank slot of a request is addr[COL_W+SLOT_W-1:COL_W], with rank in the upper RANK_W bits of that field and bank in the lower BANK_W bits. With the defaults (COL_W=4, BANK_W=3, RANK_W=1), the slot is addr[7:4], rank is addr[7] and bank is addr[6:4]. The request appears on bank_req_valid bit (rank*8+bank) and in lane slot of bank_req_addr.
- R2: The request queue holds QDEPTH (default 8) entries. enq_ready is low while it is full, and a request offered while enq_ready is low is never dispatched.
- R3: Up to DEQ_W (default 2) queue entries leave in one cycle, each to a different bank, taken strictly from the head in queue order.
- R4: bank_req_valid[b] is high only in a cycle where bank_req_ready[b] is high, and each such cycle is one transfer.
- R5: Two consecutive entries for the same bank are sent in queue order over successive cycles.
- R6: If the head entry's bank is not ready, nothing is dispatched that cycle, including later entries whose banks are ready.
- R7: At most one bank_rsp_ready bit is high per cycle, and only for a bank with bank_rsp_valid high. The accepted data appears on rsp_data with its slot on rsp_bank, in acceptance order, starting the cycle after acceptance.
- R8: After a grant to slot g, the search for the next grant starts at slot g+1 and wraps. After reset it starts at slot 0. Without a grant the start point is unchanged.
- R9: While the response queue holds RQ_DEPTH (default 4) entries, every bank_rsp_ready bit is low.
- R10: After reset both queues are empty: enq_ready is 1, rsp_valid is 0 and no bank_req_valid bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Request offered to the queue |
| enq_ready | output | 1 | Queue has room |
| enq_addr | input | ADDR_W | Request address |
| bank_req_valid | output | NBANK | Per-bank dispatch strobe (transfer) |
| bank_req_ready | input | NBANK | Bank scheduler can take a request |
| bank_req_addr | output | NBANK*ADDR_W | Per-bank request address lanes |
| bank_rsp_valid | input | NBANK | Bank offers a completion |
| bank_rsp_data | input | NBANK*DATA_W | Per-bank completion data lanes |
| bank_rsp_ready | output | NBANK | Completion accepted from that bank |
| rsp_valid | output | 1 | Response queue not empty |
| rsp_ready | input | 1 | Consumer pops the response head |
| rsp_data | output | DATA_W | Response head data |
| rsp_bank | output | SLOT_W | Bank slot that produced the response head |

## Verification
The assertions check on every cycle that a dispatch only goes to a ready bank and never exceeds the per-cycle limit, that no more entries are popped than are held, and that at most one completion is granted and only to a requesting bank. They also check that the response queue is never written while full and that the arbiter pointer holds when nothing is granted. Address slicing, in-order blocking behind a stalled head, same-bank serialisation over two cycles, the exact round-robin rotation order and the response ordering with bank tags depend on chosen address and ready patterns. Only the bench scenarios can show these.

// File: rtl/rbd_pkg.sv
// Package: shared helper for the rank/bank dispatcher.
// Assumes slot field widths below 32 bits.
package rbd_pkg;
    // Extract the bank-slot field (rank above bank) from an address.
    function automatic int unsigned slot_of(input logic [31:0] addr,
                                            input int unsigned col_w,
                                            input int unsigned slot_w);
        return (addr >> col_w) & ((32'd1 << slot_w) - 32'd1);
    endfunction
endpackage

// File: rtl/rbd_req_queue.sv
// Module: central request queue with multi-entry peek and multi-pop.
// Exposes the PEEK oldest entries; the consumer pops 0..PEEK per cycle.
// Assumes DEPTH is a power of two and PEEK <= DEPTH.
module rbd_req_queue #(
    parameter int AW    = 12,
    parameter int DEPTH = 8,
    parameter int PEEK  = 2,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int TAKE_W = $clog2(PEEK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [AW-1:0]     push_addr,
    output logic [PEEK-1:0]   head_valid,
    output logic [AW-1:0]     head_addr [PEEK],
    input  logic [TAKE_W-1:0] pop_cnt
);
    logic [AW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             push;

    assign push_ready = (count < CNT_W'(DEPTH));
    assign push       = push_valid && push_ready;

    // Present the oldest PEEK entries and whether each is occupied.
    always_comb begin
        for (int i = 0; i < PEEK; i++) begin
            head_valid[i] = (count > CNT_W'(i));
            head_addr[i]  = mem[PTR_W'(rd_ptr + PTR_W'(i))];
        end
    end

    // Write new entries into storage.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_addr;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            rd_ptr <= rd_ptr + PTR_W'(pop_cnt);
            count  <= count + CNT_W'(push) - CNT_W'(pop_cnt);
        end
    end

    AST_POP_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(pop_cnt) <= count); // R3
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R2
endmodule

// File: rtl/rbd_rr_arb.sv
// Module: round-robin arbiter with a registered priority pointer.
// Grants one requester per cycle when enabled; the pointer moves to the slot
// after the winner only on a grant.
module rbd_rr_arb #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             enable,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] gidx
);
    logic [IDX_W-1:0] ptr;

    // Search from the pointer, wrapping, for the first requester.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        gidx  = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (!found && enable && req[j]) begin
                found    = 1'b1;
                grant[j] = 1'b1;
                gidx     = IDX_W'(j);
            end
        end
    end

    // Move priority past the winner on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (|grant) ptr <= IDX_W'((int'(gidx) + 1) % N);
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0); // R7
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|grant) |=> $stable(ptr)); // R8
endmodule

// File: rtl/rbd_rsp_fifo.sv
// Module: shared response queue, single push and single pop per cycle.
// Assumes DEPTH is a power of two; the writer must respect full.
module rbd_rsp_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         pop
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop;

    assign full      = (count == CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign do_pop    = pop && out_valid;

    // Store accepted responses.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Track pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop) rd_ptr <= rd_ptr + PTR_W'(1);
            count <= count + CNT_W'(push) - CNT_W'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R9
endmodule

// File: rtl/rank_bank_dispatch.sv
// Module: rank/bank request dispatcher with round-robin response merge.
// Decodes the slot (rank above bank, above the column bits) of each queued
// request and hands up to DEQ_W head entries per cycle to distinct ready
// banks in queue order. Completions are merged round-robin into one queue.
// A bank_req_valid bit marks a transfer: it is raised only with ready.
module rank_bank_dispatch
    import rbd_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int COL_W    = 4,
    parameter int BANK_W   = 3,
    parameter int RANK_W   = 1,
    parameter int QDEPTH   = 8,
    parameter int DEQ_W    = 2,
    parameter int RQ_DEPTH = 4,
    parameter int DATA_W   = 8,
    localparam int SLOT_W  = BANK_W + RANK_W,
    localparam int NBANK   = 1 << SLOT_W,
    localparam int TAKE_W  = $clog2(DEQ_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enq_valid,
    output logic                      enq_ready,
    input  logic [ADDR_W-1:0]         enq_addr,
    output logic [NBANK-1:0]          bank_req_valid,
    input  logic [NBANK-1:0]          bank_req_ready,
    output logic [NBANK*ADDR_W-1:0]   bank_req_addr,
    input  logic [NBANK-1:0]          bank_rsp_valid,
    input  logic [NBANK*DATA_W-1:0]   bank_rsp_data,
    output logic [NBANK-1:0]          bank_rsp_ready,
    output logic                      rsp_valid,
    input  logic                      rsp_ready,
    output logic [DATA_W-1:0]         rsp_data,
    output logic [SLOT_W-1:0]         rsp_bank
);
    logic [DEQ_W-1:0]  head_valid;
    logic [ADDR_W-1:0] head_addr [DEQ_W];
    logic [SLOT_W-1:0] head_slot [DEQ_W];
    logic [TAKE_W-1:0] take;

    rbd_req_queue #(.AW(ADDR_W), .DEPTH(QDEPTH), .PEEK(DEQ_W)) u_reqq (
        .clk(clk), .rst_n(rst_n),
        .push_valid(enq_valid), .push_ready(enq_ready), .push_addr(enq_addr),
        .head_valid(head_valid), .head_addr(head_addr), .pop_cnt(take)
    );

    // Slice the rank/bank slot out of each visible head entry (R1).
    for (genvar i = 0; i < DEQ_W; i++) begin : g_slot
        assign head_slot[i] = SLOT_W'(slot_of(32'(head_addr[i]), COL_W, SLOT_W));
    end

    // In-order dispatch: stop at the first entry that cannot go this cycle.
    always_comb begin
        logic run;
        run            = 1'b1;
        take           = '0;
        bank_req_valid = '0;
        bank_req_addr  = '0;
        for (int i = 0; i < DEQ_W; i++) begin
            if (run && head_valid[i] && bank_req_ready[head_slot[i]]
                    && !bank_req_valid[head_slot[i]]) begin
                bank_req_valid[head_slot[i]] = 1'b1;
                bank_req_addr[int'(head_slot[i])*ADDR_W +: ADDR_W] = head_addr[i];
                take = take + TAKE_W'(1);
            end else begin
                run = 1'b0;
            end
        end
    end

    logic              rsp_full;
    logic [SLOT_W-1:0] win;
    logic [SLOT_W+DATA_W-1:0] push_word, head_word;

    rbd_rr_arb #(.N(NBANK)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(bank_rsp_valid), .enable(!rsp_full),
        .grant(bank_rsp_ready), .gidx(win)
    );

    // Tag the winning completion with its slot.
    assign push_word = {win, bank_rsp_data[int'(win)*DATA_W +: DATA_W]};

    rbd_rsp_fifo #(.W(SLOT_W + DATA_W), .DEPTH(RQ_DEPTH)) u_rspq (
        .clk(clk), .rst_n(rst_n), .push(|bank_rsp_ready), .push_data(push_word),
        .full(rsp_full), .out_valid(rsp_valid), .out_data(head_word), .pop(rsp_ready)
    );

    assign {rsp_bank, rsp_data} = head_word;

    AST_REQ_HAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_req_valid & ~bank_req_ready) == '0); // R4
    AST_DEQ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_req_valid) <= DEQ_W); // R3
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_full |-> (bank_rsp_ready == '0)); // R9
endmodule

// File: tb/rank_bank_dispatch_bench.sv
module rank_bank_dispatch_bench;
    localparam int AW = 12, DW = 8, NB = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enq_valid = 1'b0;
    logic            enq_ready;
    logic [AW-1:0]   enq_addr = '0;
    logic [NB-1:0]   bank_req_valid;
    logic [NB-1:0]   bank_req_ready = '0;
    logic [NB*AW-1:0] bank_req_addr;
    logic [NB-1:0]   bank_rsp_valid = '0;
    logic [NB*DW-1:0] bank_rsp_data;
    logic [NB-1:0]   bank_rsp_ready;
    logic            rsp_valid;
    logic            rsp_ready = 1'b0;
    logic [DW-1:0]   rsp_data;
    logic [3:0]      rsp_bank;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    // Each bank returns its own slot number as completion data.
    for (genvar b = 0; b < NB; b++) begin : g_data
        assign bank_rsp_data[b*DW +: DW] = DW'(b);
    end

    rank_bank_dispatch u_rank_bank_dispatch (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_addr(enq_addr),
        .bank_req_valid(bank_req_valid), .bank_req_ready(bank_req_ready),
        .bank_req_addr(bank_req_addr),
        .bank_rsp_valid(bank_rsp_valid), .bank_rsp_data(bank_rsp_data),
        .bank_rsp_ready(bank_rsp_ready),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_bank(rsp_bank)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Vector: addr A, addr B, ready mask, first-cycle mask, second-cycle mask.
    localparam logic [71:0] VEC [6] = '{
        {12'h010, 12'h020, 16'hFFFF, 16'h0006, 16'h0000},  // R3 two banks
        {12'h0A5, 12'h035, 16'hFFFF, 16'h0408, 16'h0000},  // R1 rank1 bank2
        {12'h050, 12'h05F, 16'hFFFF, 16'h0020, 16'h0020},  // R5 same bank
        {12'h060, 12'h070, 16'hFFBF, 16'h0000, 16'h00C0},  // R6 head blocked
        {12'h080, 12'h090, 16'h0100, 16'h0100, 16'h0200},  // R4 partial ready
        {12'h1F0, 12'h0E0, 16'hFFFF, 16'hC000, 16'h0000}   // R1 top slots
    };

    initial begin
        do_reset();
        // R10: reset state
        #2;
        chk("R10 enq_ready", 64'(enq_ready), 64'd1);
        chk("R10 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R10 bank_req_valid", 64'(bank_req_valid), 64'd0);
        chk("R10 bank_rsp_ready", 64'(bank_rsp_ready), 64'd0);

        // Table walk over dispatch patterns.
        foreach (VEC[v]) begin
            logic [11:0] a, b;
            logic [15:0] rdy, e1, e2;
            {a, b, rdy, e1, e2} = VEC[v];
            @(negedge clk);
            bank_req_ready = '0;
            enq_valid = 1'b1; enq_addr = a;
            @(negedge clk);
            enq_addr = b;
            @(negedge clk);
            enq_valid = 1'b0;
            bank_req_ready = rdy;
            #2;
            chk($sformatf("R3 vec%0d first mask", v), 64'(bank_req_valid), 64'(e1));
            if (e1[a[7:4]])
                chk($sformatf("R1 vec%0d addr lane", v),
                    64'(bank_req_addr[a[7:4]*AW +: AW]), 64'(a));
            @(negedge clk);
            bank_req_ready = '1;
            #2;
            chk($sformatf("R5 vec%0d second mask", v), 64'(bank_req_valid), 64'(e2));
            if (v == 2)
                chk("R5 second entry addr", 64'(bank_req_addr[5*AW +: AW]), 64'h05F);
            @(negedge clk);
            #2;
            chk($sformatf("R6 vec%0d drained", v), 64'(bank_req_valid), 64'd0);
        end

        // R2: fill queue, offer a ninth request while full.
        do_reset();
        bank_req_ready = '0;
        for (int i = 0; i < 8; i++) begin
            enq_valid = 1'b1; enq_addr = AW'(i << 4);
            @(negedge clk);
        end
        chk("R2 enq_ready low when full", 64'(enq_ready), 64'd0);
        enq_addr = 12'h0F0;
        @(negedge clk);
        enq_valid = 1'b0;
        bank_req_ready = '1;
        begin
            int sent;
            bit saw15;
            sent = 0; saw15 = 1'b0;
            for (int c = 0; c < 8; c++) begin
                #2;
                sent += $countones(bank_req_valid);
                if (bank_req_valid[15]) saw15 = 1'b1;
                @(negedge clk);
            end
            chk("R2 dispatched count", 64'(sent), 64'd8);
            chk("R2 rejected request never sent", 64'(saw15), 64'd0);
        end
        bank_req_ready = '0;

        // R8: rotation from reset pointer 0.
        do_reset();
        bank_rsp_valid = 16'h8001;
        #2;
        chk("R8 first grant slot0", 64'(bank_rsp_ready), 64'h0001);
        @(negedge clk); #2;
        chk("R8 next grant slot15", 64'(bank_rsp_ready), 64'h8000);
        @(negedge clk);
        bank_rsp_valid = '0;

        // R7/R9: fill the response queue from slots 3 and 5.
        do_reset();
        bank_rsp_valid = 16'h0028;
        begin
            logic [15:0] exp_g [5] = '{16'h0008, 16'h0020, 16'h0008, 16'h0020, 16'h0000};
            for (int c = 0; c < 5; c++) begin
                #2;
                chk($sformatf("R9 grant step %0d", c), 64'(bank_rsp_ready), 64'(exp_g[c]));
                @(negedge clk);
            end
        end
        chk("R9 still blocked while full", 64'(bank_rsp_ready), 64'd0);
        bank_rsp_valid = '0;
        rsp_ready = 1'b1;
        begin
            logic [3:0] exp_s [4] = '{4'd3, 4'd5, 4'd3, 4'd5};
            for (int c = 0; c < 4; c++) begin
                #2;
                chk($sformatf("R7 rsp_bank %0d", c), 64'(rsp_bank), 64'(exp_s[c]));
                chk($sformatf("R7 rsp_data %0d", c), 64'(rsp_data), 64'(exp_s[c]));
                @(negedge clk);
            end
        end
        #2;
        chk("R7 queue empty after drain", 64'(rsp_valid), 64'd0);
        // Pointer sits at 6 after the last grant to 5: slot 9 wins over 3.
        @(negedge clk);
        bank_rsp_valid = 16'h0208;
        #2;
        chk("R8 wrap priority slot9", 64'(bank_rsp_ready), 64'h0200);
        @(negedge clk); #2;
        chk("R8 then slot3", 64'(bank_rsp_ready), 64'h0008);
        @(negedge clk);
        bank_rsp_valid = '0;
        rsp_ready = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule